// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This controller sits beside a microcontroller core and decides when the device leaves normal running for one of four reduced-power states, and when it comes back. The core's wait-for-interrupt and wait-for-event strobes are the triggers. Three mode flags pick the target. A deep flag and a power-down flag choose between light sleep, the clock-stopped state and the powered-down state. A regulator flag turns plain sleep into the low-power variant. The controller turns its state into gating enables for the CPU clock, the memory-interface clock, the peripheral bridge clock and each oscillator. It also drives a RAM power-down request and the system clock source select.

Entry into the two deep states is held back while a flash programming operation or a peripheral-bus transfer is still running. The two deep states are left in different ways. The clock-stopped state wakes on any enabled external interrupt line and resumes on whichever internal RC a wake-clock bit names, with all range settings kept. The powered-down state wakes only on a reset-class source. It then restarts on the multi-speed RC, emits a one-cycle restore pulse, and returns that oscillator's range code to its default. The state register runs on an always-on low-speed clock, so wakeup inputs are sampled while every fast clock is gated.

Top module: `lpm_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), lp_mode is 0 (run), sysclk_sel is 0 (multi-speed RC), msrc_range is RANGE_DEFAULT (5), standby_reset is 0 and cpu_clk_en is 1.
- R2: In run, wfi or wfe with deep_sleep clear and lp_regulator clear moves lp_mode to 1 (sleep) on the next edge. In sleep, cpu_clk_en is 0, mem_clk_en equals mem_sleep_en, and the oscillator enables follow their request inputs.
- R3: The same trigger with lp_regulator set moves lp_mode to 2 (low-power sleep). There, mem_clk_en is 0 and ram_pd is 1. ram_pd is 0 in every other mode.
- R4: In modes 1 and 2, bridge_clk_en is 1 exactly when at least one bit of periph_en is set. It is 1 in modes 0 and 3, and 0 in modes 4 and 5.
- R5: In modes 1 and 2, core_wake returns lp_mode to 0 on the next edge. Other inputs do not end sleep.
- R6: In run, a trigger with deep_sleep set and no activity pending enters lp_mode 4 (stop) when pwr_down_sel is 0, and lp_mode 5 (standby) when it is 1.
- R7: If flash_busy or pbus_busy is high when a deep trigger is taken, lp_mode becomes 3 (entry wait). In mode 3, cpu_clk_en is 0 and mem_clk_en and bridge_clk_en are 1. The mode latched at the trigger is entered on the first edge at which both busy inputs are low.
- R8: In modes 4 and 5, pll_en, xosc_en and msrc_en are 0. rc16_en is 0 in mode 5, and in mode 4 it equals rc16_keep.
- R9: In stop, any bit set in both ext_irq_pend and ext_irq_en returns lp_mode to 0 on the next edge. sysclk_sel then becomes 1 (16 MHz RC) if wake_clk_rc16 is 1, else 0, and msrc_range is unchanged. A pending line whose enable is clear has no effect.
- R10: In standby, a wake_pin rising edge (pin high with the previous-cycle sample low), any rtc_evt bit, ext_rst_req or wdog_rst_req returns lp_mode to 0 with sysclk_sel 0. standby_reset is 1 for that one cycle only, and msrc_range reads RANGE_DEFAULT from the following cycle. A wake_pin held high and ext_irq lines have no effect in standby.
- R11: In run, clk_sel_wr loads clk_sel_wdata into sysclk_sel and range_wr loads range_wdata into msrc_range on the next edge. In other modes both writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | always-on low-speed clock |
| rst_n | input | 1 | synchronous active-low reset |
| wfi | input | 1 | wait-for-interrupt strobe from core |
| wfe | input | 1 | wait-for-event strobe from core |
| deep_sleep | input | 1 | selects a deep state on trigger |
| pwr_down_sel | input | 1 | deep target: 0 stop, 1 standby |
| lp_regulator | input | 1 | selects low-power sleep over sleep |
| rc16_keep | input | 1 | keeps 16 MHz RC running in stop |
| wake_clk_rc16 | input | 1 | stop wake clock: 1 16 MHz RC, 0 multi-speed RC |
| mem_sleep_en | input | 1 | memory clock request during sleep |
| periph_en | input | N_PERIPH | clock enables of peripherals on the bridge |
| flash_busy | input | 1 | flash program operation in progress |
| pbus_busy | input | 1 | peripheral-bus access in progress |
| core_wake | input | 1 | interrupt or event to the core |
| ext_irq_pend | input | N_EXTI | external interrupt lines pending |
| ext_irq_en | input | N_EXTI | external interrupt line enables |
| wake_pin | input | 1 | wakeup pin level |
| rtc_evt | input | N_RTC | RTC alarm, wakeup, tamper, timestamp events |
| ext_rst_req | input | 1 | external reset pin request |
| wdog_rst_req | input | 1 | independent watchdog reset request |
| pll_req | input | 1 | software PLL enable |
| xosc_req | input | 1 | software external oscillator enable |
| rc16_req | input | 1 | software 16 MHz RC enable |
| msrc_req | input | 1 | software multi-speed RC enable |
| clk_sel_wr | input | 1 | system clock select write strobe |
| clk_sel_wdata | input | 2 | 0 msrc, 1 rc16, 2 xosc, 3 pll |
| range_wr | input | 1 | multi-speed RC range write strobe |
| range_wdata | input | RANGE_W | range code to write |
| cpu_clk_en | output | 1 | CPU clock enable |
| mem_clk_en | output | 1 | memory-interface clock enable |
| ram_pd | output | 1 | RAM power-down request |
| bridge_clk_en | output | 1 | peripheral bridge clock enable |
| pll_en | output | 1 | PLL enable |
| xosc_en | output | 1 | external oscillator enable |
| rc16_en | output | 1 | 16 MHz RC enable |
| msrc_en | output | 1 | multi-speed RC enable |
| sysclk_sel | output | 2 | system clock source |
| msrc_range | output | RANGE_W | multi-speed RC range code |
| standby_reset | output | 1 | one-cycle restore pulse on standby exit |
| lp_mode | output | 3 | 0 run, 1 sleep, 2 lp sleep, 3 entry wait, 4 stop, 5 standby |

## Verification
All gating enables and ram_pd decode combinationally from the state register. They are due one edge after the trigger, wake or busy release that moves the state. sysclk_sel, standby_reset and range writes are due on that same edge. The range restore after standby is due one edge later, because it is driven by the registered pulse. The bench applies inputs just after a falling edge and steps a reference model at the rising edge. It compares every output at the next falling edge, so each result is read exactly one edge after its cause. The two-edge range restore is checked on the following step.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode controller.
// Assumes: state encodings are visible at the lp_mode port and must stay fixed.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_SLEEP   = 3'd1,
        ST_LPSLEEP = 3'd2,
        ST_WAIT    = 3'd3,
        ST_STOP    = 3'd4,
        ST_STANDBY = 3'd5
    } lpm_state_t;

    typedef enum logic [1:0] {
        SRC_MSRC = 2'd0,
        SRC_RC16 = 2'd1,
        SRC_XOSC = 2'd2,
        SRC_PLL  = 2'd3
    } clk_src_t;
endpackage

// File: rtl/lpm_wake_detect.sv
// Wakeup qualification for the two deep states.
// stop_wake: any external line both pending and enabled.
// standby_wake: reset-class sources, with the wake pin taken on its rising edge only.
// Assumes: inputs are already synchronous to clk_aon.
module lpm_wake_detect #(
    parameter int N_EXTI = 16,
    parameter int N_RTC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXTI-1:0] ext_irq_pend,
    input  logic [N_EXTI-1:0] ext_irq_en,
    input  logic              wake_pin,
    input  logic [N_RTC-1:0]  rtc_evt,
    input  logic              ext_rst_req,
    input  logic              wdog_rst_req,
    output logic              stop_wake,
    output logic              standby_wake
);
    logic [N_EXTI-1:0] line_hit;
    logic              pin_q;
    logic              pin_rise;

    // Per-line qualification of pending external interrupts.
    for (genvar i = 0; i < N_EXTI; i++) begin : g_line
        assign line_hit[i] = ext_irq_pend[i] & ext_irq_en[i];
    end

    // Previous-cycle sample of the wake pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= wake_pin;
    end

    // Combine wake sources per target state.
    always_comb begin
        pin_rise     = wake_pin & ~pin_q;
        stop_wake    = |line_hit;
        standby_wake = pin_rise | (|rtc_evt) | ext_rst_req | wdog_rst_req;
    end
endmodule

// File: rtl/lpm_fsm.sv
// Mode state machine: entry decisions, deferral on pending activity, exits.
// Assumes: mode flags are quasi-static; the deep target is latched at the trigger.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic       deep_sleep,
    input  logic       pwr_down_sel,
    input  logic       lp_regulator,
    input  logic       busy,
    input  logic       core_wake,
    input  logic       stop_wake,
    input  logic       standby_wake,
    output lpm_state_t state,
    output logic       stop_exit,
    output logic       standby_exit,
    output logic       standby_reset
);
    lpm_state_t state_d;
    logic       tgt_standby_q;
    logic       tgt_standby_d;

    // Exit qualifiers shared with the clock configuration block.
    always_comb begin
        stop_exit    = (state == ST_STOP) && stop_wake;
        standby_exit = (state == ST_STANDBY) && standby_wake;
    end

    // Next-state selection.
    always_comb begin
        state_d       = state;
        tgt_standby_d = tgt_standby_q;
        unique case (state)
            ST_RUN: begin
                if (trig) begin
                    if (!deep_sleep) begin
                        state_d = lp_regulator ? ST_LPSLEEP : ST_SLEEP;
                    end else begin
                        tgt_standby_d = pwr_down_sel;
                        if (busy)              state_d = ST_WAIT;
                        else if (pwr_down_sel) state_d = ST_STANDBY;
                        else                   state_d = ST_STOP;
                    end
                end
            end
            ST_SLEEP, ST_LPSLEEP: begin
                if (core_wake) state_d = ST_RUN;
            end
            ST_WAIT: begin
                if (!busy) state_d = tgt_standby_q ? ST_STANDBY : ST_STOP;
            end
            ST_STOP: begin
                if (stop_exit) state_d = ST_RUN;
            end
            ST_STANDBY: begin
                if (standby_exit) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State, latched deep target and restore pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_RUN;
            tgt_standby_q <= 1'b0;
            standby_reset <= 1'b0;
        end else begin
            state         <= state_d;
            tgt_standby_q <= tgt_standby_d;
            standby_reset <= standby_exit;
        end
    end
endmodule

// File: rtl/lpm_clk_cfg.sv
// System clock source and multi-speed RC range registers.
// Software writes are taken only in run; exits override the source; the
// restore pulse returns the range to its default and wins over a write.
module lpm_clk_cfg
    import lpm_pkg::*;
#(
    parameter int RANGE_W       = 3,
    parameter int RANGE_DEFAULT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_run,
    input  logic               stop_exit,
    input  logic               standby_exit,
    input  logic               range_restore,
    input  logic               wake_clk_rc16,
    input  logic               clk_sel_wr,
    input  logic [1:0]         clk_sel_wdata,
    input  logic               range_wr,
    input  logic [RANGE_W-1:0] range_wdata,
    output clk_src_t           sysclk_sel,
    output logic [RANGE_W-1:0] msrc_range
);
    localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'(RANGE_DEFAULT);

    // Source select: reset and exits first, then software writes in run.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sysclk_sel <= SRC_MSRC;
        else if (standby_exit)         sysclk_sel <= SRC_MSRC;
        else if (stop_exit)            sysclk_sel <= wake_clk_rc16 ? SRC_RC16 : SRC_MSRC;
        else if (in_run && clk_sel_wr) sysclk_sel <= clk_src_t'(clk_sel_wdata);
    end

    // Range code: restore pulse beats a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  msrc_range <= RANGE_RST;
        else if (range_restore)      msrc_range <= RANGE_RST;
        else if (in_run && range_wr) msrc_range <= range_wdata;
    end
endmodule

// File: rtl/lpm_gate_decode.sv
// Decodes the mode into clock gating, RAM power-down and oscillator enables.
// Purely combinational; assumes the request inputs are the software settings.
module lpm_gate_decode
    import lpm_pkg::*;
#(
    parameter int N_PERIPH = 8
) (
    input  lpm_state_t          state,
    input  logic                mem_sleep_en,
    input  logic [N_PERIPH-1:0] periph_en,
    input  logic                rc16_keep,
    input  logic                pll_req,
    input  logic                xosc_req,
    input  logic                rc16_req,
    input  logic                msrc_req,
    output logic                cpu_clk_en,
    output logic                mem_clk_en,
    output logic                ram_pd,
    output logic                bridge_clk_en,
    output logic                pll_en,
    output logic                xosc_en,
    output logic                rc16_en,
    output logic                msrc_en
);
    logic any_periph;

    // Per-mode enable table.
    always_comb begin
        any_periph    = |periph_en;
        cpu_clk_en    = 1'b0;
        mem_clk_en    = 1'b1;
        ram_pd        = 1'b0;
        bridge_clk_en = 1'b1;
        pll_en        = pll_req;
        xosc_en       = xosc_req;
        rc16_en       = rc16_req;
        msrc_en       = msrc_req;
        unique case (state)
            ST_RUN:  cpu_clk_en = 1'b1;
            ST_WAIT: ;
            ST_SLEEP: begin
                mem_clk_en    = mem_sleep_en;
                bridge_clk_en = any_periph;
            end
            ST_LPSLEEP: begin
                mem_clk_en    = 1'b0;
                ram_pd        = 1'b1;
                bridge_clk_en = any_periph;
            end
            ST_STOP, ST_STANDBY: begin
                mem_clk_en    = 1'b0;
                bridge_clk_en = 1'b0;
                pll_en        = 1'b0;
                xosc_en       = 1'b0;
                msrc_en       = 1'b0;
                rc16_en       = (state == ST_STOP) && rc16_keep;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpm_ctrl.sv
// Low-power mode controller top. Runs on the always-on clock so wakeup
// sources are seen while fast clocks are gated. Inputs are assumed synchronous.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_PERIPH      = 8,
    parameter int N_EXTI        = 16,
    parameter int N_RTC         = 4,
    parameter int RANGE_W       = 3,
    parameter int RANGE_DEFAULT = 5
) (
    input  logic                clk_aon,
    input  logic                rst_n,
    input  logic                wfi,
    input  logic                wfe,
    input  logic                deep_sleep,
    input  logic                pwr_down_sel,
    input  logic                lp_regulator,
    input  logic                rc16_keep,
    input  logic                wake_clk_rc16,
    input  logic                mem_sleep_en,
    input  logic [N_PERIPH-1:0] periph_en,
    input  logic                flash_busy,
    input  logic                pbus_busy,
    input  logic                core_wake,
    input  logic [N_EXTI-1:0]   ext_irq_pend,
    input  logic [N_EXTI-1:0]   ext_irq_en,
    input  logic                wake_pin,
    input  logic [N_RTC-1:0]    rtc_evt,
    input  logic                ext_rst_req,
    input  logic                wdog_rst_req,
    input  logic                pll_req,
    input  logic                xosc_req,
    input  logic                rc16_req,
    input  logic                msrc_req,
    input  logic                clk_sel_wr,
    input  logic [1:0]          clk_sel_wdata,
    input  logic                range_wr,
    input  logic [RANGE_W-1:0]  range_wdata,
    output logic                cpu_clk_en,
    output logic                mem_clk_en,
    output logic                ram_pd,
    output logic                bridge_clk_en,
    output logic                pll_en,
    output logic                xosc_en,
    output logic                rc16_en,
    output logic                msrc_en,
    output logic [1:0]          sysclk_sel,
    output logic [RANGE_W-1:0]  msrc_range,
    output logic                standby_reset,
    output logic [2:0]          lp_mode
);
    lpm_state_t state;
    clk_src_t   src;
    logic       stop_wake, standby_wake, stop_exit, standby_exit;

    lpm_wake_detect #(.N_EXTI(N_EXTI), .N_RTC(N_RTC)) u_wake (
        .clk          (clk_aon),
        .rst_n        (rst_n),
        .ext_irq_pend (ext_irq_pend),
        .ext_irq_en   (ext_irq_en),
        .wake_pin     (wake_pin),
        .rtc_evt      (rtc_evt),
        .ext_rst_req  (ext_rst_req),
        .wdog_rst_req (wdog_rst_req),
        .stop_wake    (stop_wake),
        .standby_wake (standby_wake)
    );

    lpm_fsm u_fsm (
        .clk           (clk_aon),
        .rst_n         (rst_n),
        .trig          (wfi | wfe),
        .deep_sleep    (deep_sleep),
        .pwr_down_sel  (pwr_down_sel),
        .lp_regulator  (lp_regulator),
        .busy          (flash_busy | pbus_busy),
        .core_wake     (core_wake),
        .stop_wake     (stop_wake),
        .standby_wake  (standby_wake),
        .state         (state),
        .stop_exit     (stop_exit),
        .standby_exit  (standby_exit),
        .standby_reset (standby_reset)
    );

    lpm_clk_cfg #(.RANGE_W(RANGE_W), .RANGE_DEFAULT(RANGE_DEFAULT)) u_cfg (
        .clk           (clk_aon),
        .rst_n         (rst_n),
        .in_run        (state == ST_RUN),
        .stop_exit     (stop_exit),
        .standby_exit  (standby_exit),
        .range_restore (standby_reset),
        .wake_clk_rc16 (wake_clk_rc16),
        .clk_sel_wr    (clk_sel_wr),
        .clk_sel_wdata (clk_sel_wdata),
        .range_wr      (range_wr),
        .range_wdata   (range_wdata),
        .sysclk_sel    (src),
        .msrc_range    (msrc_range)
    );

    lpm_gate_decode #(.N_PERIPH(N_PERIPH)) u_gate (
        .state         (state),
        .mem_sleep_en  (mem_sleep_en),
        .periph_en     (periph_en),
        .rc16_keep     (rc16_keep),
        .pll_req       (pll_req),
        .xosc_req      (xosc_req),
        .rc16_req      (rc16_req),
        .msrc_req      (msrc_req),
        .cpu_clk_en    (cpu_clk_en),
        .mem_clk_en    (mem_clk_en),
        .ram_pd        (ram_pd),
        .bridge_clk_en (bridge_clk_en),
        .pll_en        (pll_en),
        .xosc_en       (xosc_en),
        .rc16_en       (rc16_en),
        .msrc_en       (msrc_en)
    );

    // Port views of internal typed values.
    always_comb begin
        lp_mode    = state;
        sysclk_sel = src;
    end
endmodule

// File: rtl/lpm_ctrl_chk.sv
// Protocol checker for lpm_ctrl, bound to every instance of the top.
module lpm_ctrl_chk #(
    parameter int N_PERIPH      = 8,
    parameter int RANGE_W       = 3,
    parameter int RANGE_DEFAULT = 5
) (
    input logic                clk_aon,
    input logic                rst_n,
    input logic                wfi,
    input logic                wfe,
    input logic                deep_sleep,
    input logic                flash_busy,
    input logic                pbus_busy,
    input logic [N_PERIPH-1:0] periph_en,
    input logic                rc16_keep,
    input logic                cpu_clk_en,
    input logic                mem_clk_en,
    input logic                ram_pd,
    input logic                bridge_clk_en,
    input logic                pll_en,
    input logic                xosc_en,
    input logic                rc16_en,
    input logic                msrc_en,
    input logic [1:0]          sysclk_sel,
    input logic [RANGE_W-1:0]  msrc_range,
    input logic                standby_reset,
    input logic [2:0]          lp_mode
);
    localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'(RANGE_DEFAULT);

    // R2
    cpu_gate_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (lp_mode != 3'd0) |-> !cpu_clk_en);

    // R3
    lp_ram_pd_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (lp_mode == 3'd2) |-> (ram_pd && !mem_clk_en));

    // R4
    bridge_hold_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        ((lp_mode == 3'd1 || lp_mode == 3'd2) && (|periph_en)) |-> bridge_clk_en);

    // R7
    entry_defer_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (lp_mode == 3'd0 && (wfi || wfe) && deep_sleep && (flash_busy || pbus_busy))
        |=> (lp_mode == 3'd3));

    // R8
    osc_off_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (lp_mode == 3'd4 || lp_mode == 3'd5) |-> (!pll_en && !xosc_en && !msrc_en));

    // R8
    rc16_keep_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (lp_mode == 3'd4) |-> (rc16_en == rc16_keep));

    // R10
    sb_pulse_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        standby_reset |=> !standby_reset);

    // R10
    sb_exit_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        standby_reset |-> (lp_mode == 3'd0 && sysclk_sel == 2'd0));

    // R10
    sb_range_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        standby_reset |=> (msrc_range == RANGE_RST));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(
    .N_PERIPH      (N_PERIPH),
    .RANGE_W       (RANGE_W),
    .RANGE_DEFAULT (RANGE_DEFAULT)
) u_chk (
    .clk_aon       (clk_aon),
    .rst_n         (rst_n),
    .wfi           (wfi),
    .wfe           (wfe),
    .deep_sleep    (deep_sleep),
    .flash_busy    (flash_busy),
    .pbus_busy     (pbus_busy),
    .periph_en     (periph_en),
    .rc16_keep     (rc16_keep),
    .cpu_clk_en    (cpu_clk_en),
    .mem_clk_en    (mem_clk_en),
    .ram_pd        (ram_pd),
    .bridge_clk_en (bridge_clk_en),
    .pll_en        (pll_en),
    .xosc_en       (xosc_en),
    .rc16_en       (rc16_en),
    .msrc_en       (msrc_en),
    .sysclk_sel    (sysclk_sel),
    .msrc_range    (msrc_range),
    .standby_reset (standby_reset),
    .lp_mode       (lp_mode)
);

// File: tb/lpm_ctrl_test.sv
// Bench for lpm_ctrl: directed corners then seeded random traffic, each
// cycle compared with a reference model written from the requirements.
module lpm_ctrl_test;
    localparam int NP = 8, NE = 16, NR = 4, RW = 3, RDEF = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wfi = 0, wfe = 0, deep_sleep = 0, pwr_down_sel = 0, lp_regulator = 0;
    logic rc16_keep = 0, wake_clk_rc16 = 0, mem_sleep_en = 0;
    logic [NP-1:0] periph_en = '0;
    logic flash_busy = 0, pbus_busy = 0, core_wake = 0;
    logic [NE-1:0] ext_irq_pend = '0, ext_irq_en = '0;
    logic wake_pin = 0;
    logic [NR-1:0] rtc_evt = '0;
    logic ext_rst_req = 0, wdog_rst_req = 0;
    logic pll_req = 1, xosc_req = 1, rc16_req = 1, msrc_req = 1;
    logic clk_sel_wr = 0;
    logic [1:0] clk_sel_wdata = '0;
    logic range_wr = 0;
    logic [RW-1:0] range_wdata = '0;
    logic cpu_clk_en, mem_clk_en, ram_pd, bridge_clk_en;
    logic pll_en, xosc_en, rc16_en, msrc_en;
    logic [1:0] sysclk_sel;
    logic [RW-1:0] msrc_range;
    logic standby_reset;
    logic [2:0] lp_mode;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model state.
    int m_st = 0, m_sys = 0, m_rng = RDEF;
    bit m_tgt = 0, m_sbr = 0, m_pq = 0;

    lpm_ctrl #(.N_PERIPH(NP), .N_EXTI(NE), .N_RTC(NR), .RANGE_W(RW), .RANGE_DEFAULT(RDEF)) uut (
        .clk_aon(clk), .rst_n(rst_n), .wfi(wfi), .wfe(wfe), .deep_sleep(deep_sleep),
        .pwr_down_sel(pwr_down_sel), .lp_regulator(lp_regulator), .rc16_keep(rc16_keep),
        .wake_clk_rc16(wake_clk_rc16), .mem_sleep_en(mem_sleep_en), .periph_en(periph_en),
        .flash_busy(flash_busy), .pbus_busy(pbus_busy), .core_wake(core_wake),
        .ext_irq_pend(ext_irq_pend), .ext_irq_en(ext_irq_en), .wake_pin(wake_pin),
        .rtc_evt(rtc_evt), .ext_rst_req(ext_rst_req), .wdog_rst_req(wdog_rst_req),
        .pll_req(pll_req), .xosc_req(xosc_req), .rc16_req(rc16_req), .msrc_req(msrc_req),
        .clk_sel_wr(clk_sel_wr), .clk_sel_wdata(clk_sel_wdata), .range_wr(range_wr),
        .range_wdata(range_wdata), .cpu_clk_en(cpu_clk_en), .mem_clk_en(mem_clk_en),
        .ram_pd(ram_pd), .bridge_clk_en(bridge_clk_en), .pll_en(pll_en), .xosc_en(xosc_en),
        .rc16_en(rc16_en), .msrc_en(msrc_en), .sysclk_sel(sysclk_sel),
        .msrc_range(msrc_range), .standby_reset(standby_reset), .lp_mode(lp_mode)
    );

    // 250 MHz: 4 time-unit period.
    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected gating from mode and inputs (R2 R3 R4 R8).
    function automatic int exp_mem(int st);
        if (st == 0 || st == 3) return 1;
        if (st == 1) return int'(mem_sleep_en);
        return 0;
    endfunction
    function automatic int exp_bridge(int st);
        if (st == 0 || st == 3) return 1;
        if (st == 1 || st == 2) return int'(|periph_en);
        return 0;
    endfunction
    function automatic int exp_osc(int st);
        bit deep = (st == 4 || st == 5);
        bit rc = (st == 5) ? 1'b0 : (st == 4) ? rc16_keep : rc16_req;
        return {28'd0, deep ? 1'b0 : pll_req, deep ? 1'b0 : xosc_req, rc, deep ? 1'b0 : msrc_req};
    endfunction

    // Advance the model by one rising edge using the driven inputs.
    task automatic model_edge();
        bit busy = flash_busy | pbus_busy;
        bit trig = wfi | wfe;
        bit sw = |(ext_irq_pend & ext_irq_en);
        bit bw = (wake_pin & ~m_pq) | (|rtc_evt) | ext_rst_req | wdog_rst_req;
        int n_st = m_st, n_sys = m_sys, n_rng = m_rng;
        bit n_tgt = m_tgt, n_sbr = 0;
        if (!rst_n) begin
            m_st = 0; m_sys = 0; m_rng = RDEF; m_tgt = 0; m_sbr = 0; m_pq = 0;
            return;
        end
        case (m_st)
            0: begin
                if (trig) begin
                    if (!deep_sleep) n_st = lp_regulator ? 2 : 1;
                    else begin
                        n_tgt = pwr_down_sel;
                        n_st = busy ? 3 : (pwr_down_sel ? 5 : 4);
                    end
                end
                if (clk_sel_wr) n_sys = int'(clk_sel_wdata);
            end
            1, 2: if (core_wake) n_st = 0;
            3: if (!busy) n_st = m_tgt ? 5 : 4;
            4: if (sw) begin n_st = 0; n_sys = wake_clk_rc16 ? 1 : 0; end
            5: if (bw) begin n_st = 0; n_sys = 0; n_sbr = 1; end
            default: n_st = 0;
        endcase
        if (m_sbr) n_rng = RDEF;
        else if (m_st == 0 && range_wr) n_rng = int'(range_wdata);
        m_pq = wake_pin;
        m_st = n_st; m_sys = n_sys; m_rng = n_rng; m_tgt = n_tgt; m_sbr = n_sbr;
    endtask

    // One cycle: edge, model update, compare all outputs at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R6 lp_mode", int'(lp_mode), m_st);
        check("R2 cpu_clk_en", int'(cpu_clk_en), (m_st == 0) ? 1 : 0);
        check("R3 mem_clk_en", int'(mem_clk_en), exp_mem(m_st));
        check("R3 ram_pd", int'(ram_pd), (m_st == 2) ? 1 : 0);
        check("R4 bridge_clk_en", int'(bridge_clk_en), exp_bridge(m_st));
        check("R8 osc enables", int'({pll_en, xosc_en, rc16_en, msrc_en}), exp_osc(m_st));
        check("R9 sysclk_sel", int'(sysclk_sel), m_sys);
        check("R11 msrc_range", int'(msrc_range), m_rng);
        check("R10 standby_reset", int'(standby_reset), int'(m_sbr));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd9157);
        // Reset (R1)
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        check("R1 lp_mode", int'(lp_mode), 0);
        check("R1 sysclk_sel", int'(sysclk_sel), 0);
        check("R1 msrc_range", int'(msrc_range), RDEF);
        check("R1 standby_reset", int'(standby_reset), 0);
        check("R1 cpu_clk_en", int'(cpu_clk_en), 1);

        // R2 sleep, bridge off with no peripheral enabled (R4)
        wfi = 1; step(); wfi = 0;
        check("R2 sleep entry", int'(lp_mode), 1);
        check("R4 bridge off", int'(bridge_clk_en), 0);
        periph_en = 8'h04; step();
        check("R4 bridge held", int'(bridge_clk_en), 1);
        ext_irq_pend = 1; ext_irq_en = 1; step();
        check("R5 ignore other wake", int'(lp_mode), 1);
        ext_irq_pend = 0; core_wake = 1; step(); core_wake = 0;
        check("R5 sleep exit", int'(lp_mode), 0);

        // R3 low-power sleep
        lp_regulator = 1; mem_sleep_en = 1; wfe = 1; step(); wfe = 0;
        check("R3 lp sleep", int'({lp_mode, ram_pd, mem_clk_en}), {3'd2, 1'b1, 1'b0});
        core_wake = 1; step(); core_wake = 0; lp_regulator = 0;

        // R7 deferral, then R6 stop, R8 keep-on, R9 exit
        deep_sleep = 1; pwr_down_sel = 0; flash_busy = 1; wfi = 1; step(); wfi = 0;
        check("R7 wait", int'(lp_mode), 3);
        step();
        flash_busy = 0; pbus_busy = 1; step();
        check("R7 still wait", int'(lp_mode), 3);
        pbus_busy = 0; rc16_keep = 1; step();
        check("R6 stop", int'(lp_mode), 4);
        check("R8 rc16 kept", int'(rc16_en), 1);
        ext_irq_en = 0; ext_irq_pend = 16'h0100; step();
        check("R9 masked line", int'(lp_mode), 4);
        ext_irq_en = 16'h0100; wake_clk_rc16 = 1; step();
        check("R9 stop exit", int'({lp_mode, sysclk_sel}), {3'd0, 2'd1});
        ext_irq_pend = 0; ext_irq_en = 0;

        // R11 range write, then R10 standby
        range_wr = 1; range_wdata = 3'd2; step(); range_wr = 0;
        check("R11 range write", int'(msrc_range), 2);
        wake_pin = 1; pwr_down_sel = 1; wfi = 1; step(); wfi = 0;
        check("R6 standby", int'(lp_mode), 5);
        ext_irq_pend = 1; ext_irq_en = 1; range_wr = 1; range_wdata = 3'd6; step();
        check("R10 level pin ignored", int'(lp_mode), 5);
        check("R11 write ignored", int'(msrc_range), 2);
        ext_irq_pend = 0; range_wr = 0; wake_pin = 0; step();
        wake_pin = 1; step();
        check("R10 standby exit", int'({lp_mode, standby_reset, sysclk_sel}), {3'd0, 1'b1, 2'd0});
        step();
        check("R10 range default", int'({standby_reset, msrc_range}), {1'b0, 3'(RDEF)});
        deep_sleep = 0; pwr_down_sel = 0; rc16_keep = 0; wake_clk_rc16 = 0;

        // Seeded random traffic.
        for (int i = 0; i < 4000; i++) begin
            wfi = ($urandom % 100) < 12;
            wfe = ($urandom % 100) < 5;
            deep_sleep = $urandom % 2;
            pwr_down_sel = $urandom % 2;
            lp_regulator = $urandom % 2;
            rc16_keep = $urandom % 2;
            wake_clk_rc16 = $urandom % 2;
            mem_sleep_en = $urandom % 2;
            periph_en = (($urandom % 100) < 40) ? '0 : NP'($urandom);
            flash_busy = ($urandom % 100) < 25;
            pbus_busy = ($urandom % 100) < 25;
            core_wake = ($urandom % 100) < 20;
            ext_irq_pend = (($urandom % 100) < 15) ? NE'($urandom) : '0;
            ext_irq_en = NE'($urandom);
            if (($urandom % 100) < 15) wake_pin = ~wake_pin;
            rtc_evt = (($urandom % 100) < 4) ? NR'($urandom) : '0;
            ext_rst_req = ($urandom % 100) < 3;
            wdog_rst_req = ($urandom % 100) < 3;
            {pll_req, xosc_req, rc16_req, msrc_req} = 4'($urandom);
            clk_sel_wr = ($urandom % 100) < 10;
            clk_sel_wdata = 2'($urandom);
            range_wr = ($urandom % 100) < 10;
            range_wdata = RW'($urandom);
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule